// File: doc/BRIEF.md
# Wormhole Router Input Port

This block is a single input port of a packet-switched router that uses wormhole flow control. A neighbouring switch sends flits to it over a link. Each flit carries a valid strobe, a 36-bit payload, an end-of-packet flag, a 5-bit destination node number and a one-hot field that names the output of this switch. The port returns a ready signal to the sender. Arriving flits are queued in a 16-entry FIFO.

While the queue holds a flit, the port raises a request toward the output named by the packet's one-hot field. When that output grants the port and is ready, the port forwards the head flit in the same cycle. With the flit it presents the one-hot route that the next switch should use. That route comes from a table indexed by destination and fixed by a parameter.

Ready falls while a few slots are still free. Flits already in flight after the sender sees ready fall therefore still have room.

Top module: `wormInPort`

## Requirements
- R1: Reset leaves the queue empty. After reset `outReq` is 0, `fwdValid` is 0 and `linkReady` is 1.
- R2: `outReq` is 0 whenever the queue is empty, whatever is on the link inputs. Otherwise it equals the one-hot route field of the packet at the head, where bit i selects output i.
- R3: `fwdValid` is high in exactly the cycles where the queue is non-empty and the requested output has both `outGrant` and `outReady` high. A flit written at a clock edge can be forwarded in the very next cycle.
- R4: The route field and destination are taken from the first flit of a packet, which is the first flit after reset or after a flit with `linkLast` = 1. Both are used for every flit up to and including the flit with `linkLast` set. The route and destination inputs on the other flits of the packet have no effect.
- R5: `fwdNextRoute` is the table entry for the head packet's destination. In the default table, entry d is one-hot with bit (d mod 4) set. `fwdDest` carries the destination.
- R6: `linkReady` is low when 12 or more of the 16 entries are occupied, that is when 4 or fewer are free. It is high otherwise.
- R7: Flits that arrive while `linkReady` is low are still stored, up to the full 16 entries, and none is lost.
- R8: Flits leave in arrival order, with data and last flag intact. When the port is not granted or the output is not ready, the head flit is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkValid | input | 1 | Flit present on the link |
| linkData | input | 36 | Flit payload |
| linkLast | input | 1 | Last flit of a packet |
| linkDest | input | 5 | Destination node (used from the first flit) |
| linkRoute | input | 4 | One-hot output of this switch (used from the first flit) |
| linkReady | output | 1 | Port can accept more flits |
| outGrant | input | 4 | Grant from each output's arbiter |
| outReady | input | 4 | Each output can take a flit |
| outReq | output | 4 | Request toward each output |
| fwdValid | output | 1 | Head flit is forwarded this cycle |
| fwdData | output | 36 | Payload of the head flit |
| fwdLast | output | 1 | Last flag of the head flit |
| fwdDest | output | 5 | Destination of the head packet |
| fwdNextRoute | output | 4 | One-hot route for the next switch |

## Verification
The bench fills the queue with no grant and checks the exact occupancy at which ready falls. An off-by-one slack threshold would either starve the sender or let in-flight flits overrun the queue. It then pushes four more flits past the point where ready fell. A port that dropped writes once ready was low would lose flits, and the scoreboard would report them missing.

Body flits are sent with wrong route and destination fields. A port that did not keep the first flit's values would request the wrong output or compute the wrong next-hop route. The bench also checks that no request appears while the queue is empty, which catches stale head data leaking out. It grants a different output than the one requested and expects nothing to move. It checks that a flit is forwarded in the cycle right after it is written, which catches an extra pipeline stage. Random stalls on the output test that order is kept and that the head flit is held while stalled.

// File: rtl/wormPortPkg.sv
package wormPortPkg;
  localparam int DEST_W = 5;
  localparam int NODES  = 1 << DEST_W;
  localparam int NEXT_W = 4;

  typedef struct packed {
    logic push;
    logic pop;
  } portStrobe_t;

  function automatic logic [NODES*NEXT_W-1:0] defaultTable();
    logic [NODES*NEXT_W-1:0] t;
    t = '0;
    for (int d = 0; d < NODES; d++) t[d*NEXT_W + (d % NEXT_W)] = 1'b1;
    return t;
  endfunction
endpackage

// File: rtl/wormInCtrl.sv
module wormInCtrl
  import wormPortPkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int DEPTH   = 16,
  parameter int SLACK   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               linkValid,
  input  logic [NUM_OUT-1:0] headRoute,
  input  logic [NUM_OUT-1:0] outGrant,
  input  logic [NUM_OUT-1:0] outReady,
  output portStrobe_t        strb,
  output logic [NUM_OUT-1:0] outReq,
  output logic               linkReady
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] READY_LIM = CNT_W'(DEPTH - SLACK);

  logic [CNT_W-1:0] count;
  logic notEmpty;
  logic hit;

  assign notEmpty  = (count != '0);
  assign outReq    = notEmpty ? headRoute : '0;
  assign hit       = |(headRoute & outGrant & outReady);
  assign strb.pop  = notEmpty & hit;
  assign strb.push = linkValid & (count != FULL_CNT);
  assign linkReady = (count < READY_LIM);

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else begin
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> (count != FULL_CNT));

  // R6
  ready_slack_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkReady |=> (count <= READY_LIM));

  // R2
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outReq));

  // R3
  pop_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> (|(outReq & outGrant & outReady)));
endmodule

// File: rtl/wormInData.sv
module wormInData
  import wormPortPkg::*;
#(
  parameter int DATA_W  = 36,
  parameter int NUM_OUT = 4,
  parameter int DEPTH   = 16,
  parameter logic [NODES*NEXT_W-1:0] ROUTE_TABLE = defaultTable()
) (
  input  logic               clk,
  input  logic               rstN,
  input  portStrobe_t        strb,
  input  logic [DATA_W-1:0]  linkData,
  input  logic               linkLast,
  input  logic [DEST_W-1:0]  linkDest,
  input  logic [NUM_OUT-1:0] linkRoute,
  output logic [NUM_OUT-1:0] headRoute,
  output logic [DATA_W-1:0]  fwdData,
  output logic               fwdLast,
  output logic [DEST_W-1:0]  fwdDest,
  output logic [NEXT_W-1:0]  fwdNextRoute
);
  localparam int ENT_W = DATA_W + 1 + DEST_W + NUM_OUT;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic inBody;
  logic [NUM_OUT-1:0] capRoute;
  logic [DEST_W-1:0]  capDest;
  logic [NUM_OUT-1:0] wrRoute;
  logic [DEST_W-1:0]  wrDest;
  logic [ENT_W-1:0]   headEnt;

  assign wrRoute = inBody ? capRoute : linkRoute;
  assign wrDest  = inBody ? capDest  : linkDest;

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= {linkData, linkLast, wrDest, wrRoute};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      inBody   <= 1'b0;
      capRoute <= '0;
      capDest  <= '0;
    end else begin
      if (strb.push) begin
        wrPtr    <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
        inBody   <= ~linkLast;
        capRoute <= wrRoute;
        capDest  <= wrDest;
      end
      if (strb.pop) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
    end
  end

  assign headEnt      = mem[rdPtr];
  assign headRoute    = headEnt[NUM_OUT-1:0];
  assign fwdDest      = headEnt[NUM_OUT +: DEST_W];
  assign fwdLast      = headEnt[NUM_OUT+DEST_W];
  assign fwdData      = headEnt[ENT_W-1 -: DATA_W];
  assign fwdNextRoute = ROUTE_TABLE[fwdDest*NEXT_W +: NEXT_W];

  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pop |=> $stable(rdPtr));

  // R4
  body_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && inBody) |=> $stable(capRoute) && $stable(capDest));
endmodule

// File: rtl/wormInPort.sv
module wormInPort
  import wormPortPkg::*;
#(
  parameter int DATA_W  = 36,
  parameter int NUM_OUT = 4,
  parameter int DEPTH   = 16,
  parameter int SLACK   = 4,
  parameter logic [NODES*NEXT_W-1:0] ROUTE_TABLE = defaultTable()
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               linkValid,
  input  logic [DATA_W-1:0]  linkData,
  input  logic               linkLast,
  input  logic [DEST_W-1:0]  linkDest,
  input  logic [NUM_OUT-1:0] linkRoute,
  output logic               linkReady,
  input  logic [NUM_OUT-1:0] outGrant,
  input  logic [NUM_OUT-1:0] outReady,
  output logic [NUM_OUT-1:0] outReq,
  output logic               fwdValid,
  output logic [DATA_W-1:0]  fwdData,
  output logic               fwdLast,
  output logic [DEST_W-1:0]  fwdDest,
  output logic [NEXT_W-1:0]  fwdNextRoute
);
  portStrobe_t strb;
  logic [NUM_OUT-1:0] headRoute;

  wormInCtrl #(.NUM_OUT(NUM_OUT), .DEPTH(DEPTH), .SLACK(SLACK)) ctrl (
    .clk(clk), .rstN(rstN), .linkValid(linkValid), .headRoute(headRoute),
    .outGrant(outGrant), .outReady(outReady), .strb(strb),
    .outReq(outReq), .linkReady(linkReady)
  );

  wormInData #(.DATA_W(DATA_W), .NUM_OUT(NUM_OUT), .DEPTH(DEPTH),
               .ROUTE_TABLE(ROUTE_TABLE)) data (
    .clk(clk), .rstN(rstN), .strb(strb), .linkData(linkData),
    .linkLast(linkLast), .linkDest(linkDest), .linkRoute(linkRoute),
    .headRoute(headRoute), .fwdData(fwdData), .fwdLast(fwdLast),
    .fwdDest(fwdDest), .fwdNextRoute(fwdNextRoute)
  );

  assign fwdValid = strb.pop;
endmodule

// File: tb/wormInPort_test.sv
module wormInPort_test;
  typedef struct packed {
    logic [35:0] data;
    logic        last;
    logic [4:0]  dest;
    logic [3:0]  route;
  } expFlit_t;

  logic clk = 0;
  logic rstN = 0;
  logic linkValid = 0;
  logic [35:0] linkData = '0;
  logic linkLast = 0;
  logic [4:0] linkDest = '0;
  logic [3:0] linkRoute = '0;
  logic linkReady;
  logic [3:0] outGrant, outReady, outReq;
  logic [3:0] grantMask = '0;
  logic [3:0] readyMask = 4'hF;
  logic fwdValid, fwdLast;
  logic [35:0] fwdData;
  logic [4:0] fwdDest;
  logic [3:0] fwdNextRoute;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  expFlit_t expQ[$];
  logic [3:0] pktRoute;
  logic [4:0] pktDest;
  bit inPkt = 0;

  always #4 clk = ~clk;

  assign outGrant = outReq & grantMask;
  assign outReady = readyMask;

  wormInPort uut (
    .clk(clk), .rstN(rstN), .linkValid(linkValid), .linkData(linkData),
    .linkLast(linkLast), .linkDest(linkDest), .linkRoute(linkRoute),
    .linkReady(linkReady), .outGrant(outGrant), .outReady(outReady),
    .outReq(outReq), .fwdValid(fwdValid), .fwdData(fwdData),
    .fwdLast(fwdLast), .fwdDest(fwdDest), .fwdNextRoute(fwdNextRoute)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at posedge+1; drives one flit and returns at the posedge+1 after it is written.
  task automatic sendFlit(input logic [35:0] d, input logic l,
                          input logic [4:0] dst, input logic [3:0] rt);
    expFlit_t e;
    if (!inPkt) begin
      pktRoute = rt;
      pktDest  = dst;
    end
    e.data = d; e.last = l; e.dest = pktDest; e.route = pktRoute;
    inPkt = !l;
    expQ.push_back(e);
    linkValid = 1; linkData = d; linkLast = l; linkDest = dst; linkRoute = rt;
    @(posedge clk); #1;
    linkValid = 0;
  endtask

  // Scoreboard monitor (R3, R5, R8)
  always @(negedge clk) begin
    if (rstN && fwdValid) begin
      expFlit_t e;
      if (expQ.size() == 0) begin
        check(0, "R8", "unexpected forward", {28'd0, fwdData}, 64'd0);
      end else begin
        e = expQ.pop_front();
        check(fwdData == e.data && fwdLast == e.last, "R8", "data/last",
              {27'd0, fwdData, fwdLast}, {27'd0, e.data, e.last});
        check(outReq == e.route && fwdDest == e.dest, "R4", "route/dest",
              {55'd0, outReq, fwdDest}, {55'd0, e.route, e.dest});
        check(fwdNextRoute == (4'b1 << (e.dest % 4)), "R5", "next route",
              {60'd0, fwdNextRoute}, {60'd0, 4'b1 << (e.dest % 4)});
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "WATCHDOG", "timeout", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drain();
    int guard = 0;
    while (expQ.size() != 0 && guard < 2000) begin
      @(posedge clk); #1;
      guard++;
    end
    check(expQ.size() == 0, "R8", "drain complete", expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(outReq == 0, "R1", "outReq after reset", outReq, 0);
    check(fwdValid == 0, "R1", "fwdValid after reset", fwdValid, 0);
    check(linkReady == 1, "R1", "linkReady after reset", linkReady, 1);

    // R2 empty queue: junk on link without valid gives no request
    @(posedge clk); #1;
    linkRoute = 4'b1111; linkDest = 5'd9;
    @(negedge clk);
    check(outReq == 0, "R2", "no request when empty", outReq, 0);
    @(posedge clk); #1;

    // R6 fill with no grant
    grantMask = 4'h0;
    for (int i = 0; i < 11; i++) sendFlit(36'h100 + i, 1'b1, 5'(i), 4'b0100);
    @(negedge clk);
    check(linkReady == 1, "R6", "ready at 11 entries", linkReady, 1);
    @(posedge clk); #1;
    sendFlit(36'h10B, 1'b1, 5'd11, 4'b0100);
    @(negedge clk);
    check(linkReady == 0, "R6", "ready at 12 entries", linkReady, 0);
    check(outReq == 4'b0100, "R2", "request while stalled", outReq, 4'b0100);
    check(fwdValid == 0, "R3", "no forward without grant", fwdValid, 0);
    @(posedge clk); #1;
    // R7 in-flight flits past ready are still stored
    for (int i = 12; i < 16; i++) sendFlit(36'h100 + i, 1'b1, 5'(i), 4'b0100);
    @(negedge clk);
    check(linkReady == 0, "R7", "ready low when full", linkReady, 0);
    check(expQ.size() == 16, "R7", "nothing forwarded yet", expQ.size(), 16);
    // R3 grant on a different output moves nothing
    @(posedge clk); #1;
    grantMask = 4'b1011;
    @(negedge clk);
    check(fwdValid == 0, "R3", "grant on other output", fwdValid, 0);
    @(posedge clk); #1;
    grantMask = 4'hF;
    drain();
    @(negedge clk);
    check(linkReady == 1, "R6", "ready after drain", linkReady, 1);
    check(outReq == 0, "R2", "no request after drain", outReq, 0);
    @(posedge clk); #1;

    // R4 body flits carry wrong route/dest, ignored
    grantMask = 4'h0;
    sendFlit(36'hA0, 1'b0, 5'd7, 4'b0010);
    sendFlit(36'hA1, 1'b0, 5'd3, 4'b0001);
    sendFlit(36'hA2, 1'b1, 5'd30, 4'b1000);
    grantMask = 4'hF;
    drain();
    @(posedge clk); #1;

    // R3 zero-wait forward in cycle after write
    sendFlit(36'hBEEF, 1'b1, 5'd22, 4'b1000);
    @(negedge clk);
    check(fwdValid == 1, "R3", "forward next cycle", fwdValid, 1);
    @(posedge clk); #1;
    drain();

    // R8 stress with random output stalls, honoring ready
    fork
      begin
        for (int i = 0; i < 120; i++) begin
          @(posedge clk); #2;
          readyMask = ($urandom % 3 == 0) ? 4'h0 : 4'hF;
        end
        readyMask = 4'hF;
      end
      begin
        for (int p = 0; p < 12; p++) begin
          int len = 1 + (p % 4);
          logic [3:0] rt = 4'b1 << (p % 4);
          for (int k = 0; k < len; k++) begin
            while (!linkReady) begin @(posedge clk); #1; end
            sendFlit(36'(p * 16 + k), (k == len - 1), 5'(p * 5 + k),
                     (k == 0) ? rt : 4'b0001);
          end
        end
      end
    join
    drain();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule